// File: doc/BRIEF.md
# Bitwise Compute-in-Memory Word Array

This block is a small all-digital memory built from flip-flops. Besides ordinary word writes and reads, it can combine two stored words in place. A single command names an operation and a base row. The operation reads the base row and the row above it in the same cycle, and it returns the bitwise AND, OR or XOR of the two words, or their arithmetic sum.

Commands arrive on a simple valid-qualified interface, one per clock, with no back-pressure. Every command that produces a value leaves on a single result port after a fixed latency, with a one-cycle valid strobe. Results leave in the order their commands were accepted. The sum path is a ripple-carry adder cut into two registered halves: the low half and its carry are registered first, and the high half completes one stage later. The result word is one bit wider than a stored word, so the carry-out of a sum is kept.

Top module: `bitwise_cim_array`

## Requirements
- R1: The operation code is `cmd_mode`. 000 writes `cmd_wdata` into row `cmd_row`. 001 reads row `cmd_row` and returns it zero-extended in `res_data`.
- R2: Codes 010, 011 and 100 return the bitwise AND, OR and XOR of row `cmd_row` and its partner row `cmd_row`+1, zero-extended, with `res_data[WIDTH]` = 0.
- R3: Code 101 returns the unsigned sum of row `cmd_row` and its partner row as a WIDTH+1 bit value, with the carry-out in `res_data[WIDTH]`.
- R4: For the logic and sum codes, when `cmd_row` is the last row (ROWS-1), the partner row is row 0.
- R5: A command is accepted on a rising edge with `cmd_valid` high. For codes 001 to 101, `res_valid` is high for exactly one cycle: the cycle that follows the second rising edge after the accepting edge. Writes, idle cycles and codes 110 and 111 produce no `res_valid`.
- R6: Codes 110 and 111 leave the array unchanged.
- R7: A new command may be accepted on every edge. Results come out one per cycle, in the order the commands were accepted.
- R8: An operation accepted on the edge right after a write to one of its rows uses the newly written word.
- R9: While `rst_n` is low, `res_valid` is 0. Reset clears every row to zero.
- R10: In a sum, a carry out of the low WIDTH/2 bits propagates correctly into the high half (for example, 0x0F + 0x01 = 0x010 and 0xFF + 0x01 = 0x100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_mode | input | 3 | Operation code |
| cmd_row | input | $clog2(ROWS) | Base row address |
| cmd_wdata | input | WIDTH | Write data for code 000 |
| res_valid | output | 1 | One-cycle strobe marking a result |
| res_data | output | WIDTH+1 | Read word, logic result or sum |

## Verification
The bench sweeps every row and every operation code over four data patterns. The patterns include words whose sums carry across the half boundary and out of the top bit. A design that drops the carry between the two adder stages, or trims the sum to WIDTH bits, returns a wrong high half or a zero top bit. Operations on the last row check the wrap to row 0; a design that addresses past the array would return stale or zero data there. Commands are issued back-to-back, with a write directly followed by operations on that row, with idle gaps, and with the two unused codes. These cases catch stale-data reads, dropped or duplicated strobes, misordered results, and unused codes that write or answer.

// File: rtl/bitwise_cim_array.sv
module bitwise_cim_array #(
  parameter int WIDTH = 8,
  parameter int ROWS = 8,
  localparam int AW = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_mode,
  input  logic [AW-1:0]    cmd_row,
  input  logic [WIDTH-1:0] cmd_wdata,
  output logic             res_valid,
  output logic [WIDTH:0]   res_data
);
  localparam int LO = WIDTH / 2;
  localparam int HI = WIDTH - LO;
  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_AND = 3'd2,
                         OP_OR = 3'd3, OP_XOR = 3'd4, OP_ADD = 3'd5;

  logic [WIDTH-1:0] mem [ROWS];

  logic [AW-1:0] partner;
  logic          produces;
  assign partner  = (cmd_row == AW'(ROWS - 1)) ? '0 : cmd_row + 1'b1;
  assign produces = cmd_valid && cmd_mode >= OP_RD && cmd_mode <= OP_ADD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (cmd_valid && cmd_mode == OP_WR) begin
      mem[cmd_row] <= cmd_wdata;
    end
  end

  logic             v1;
  logic [2:0]       m1;
  logic [WIDTH-1:0] a1, b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      m1 <= OP_RD;
      a1 <= '0;
      b1 <= '0;
    end else begin
      v1 <= produces;
      m1 <= cmd_mode;
      a1 <= mem[cmd_row];
      b1 <= mem[partner];
    end
  end

  logic             v2, add2;
  logic [LO:0]      lo2;
  logic [HI-1:0]    ahi2, bhi2;
  logic [WIDTH-1:0] log2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2   <= 1'b0;
      add2 <= 1'b0;
      lo2  <= '0;
      ahi2 <= '0;
      bhi2 <= '0;
      log2 <= '0;
    end else begin
      v2   <= v1;
      add2 <= (m1 == OP_ADD);
      lo2  <= {1'b0, a1[LO-1:0]} + {1'b0, b1[LO-1:0]};
      ahi2 <= a1[WIDTH-1:LO];
      bhi2 <= b1[WIDTH-1:LO];
      case (m1)
        OP_AND:  log2 <= a1 & b1;
        OP_OR:   log2 <= a1 | b1;
        OP_XOR:  log2 <= a1 ^ b1;
        default: log2 <= a1;
      endcase
    end
  end

  logic [HI:0] hi_sum;
  assign hi_sum = {1'b0, ahi2} + {1'b0, bhi2} + {{HI{1'b0}}, lo2[LO]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= v2;
      res_data  <= add2 ? {hi_sum, lo2[LO-1:0]} : {1'b0, log2};
    end
  end
endmodule

// File: rtl/bitwise_cim_array_chk.sv
module bitwise_cim_array_chk #(
  parameter int WIDTH = 8,
  parameter int AW = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [2:0]       cmd_mode,
  input logic [AW-1:0]    cmd_row,
  input logic [WIDTH-1:0] cmd_wdata,
  input logic             res_valid,
  input logic [WIDTH:0]   res_data
);
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  logic answers, is_wr, is_rd, is_add;
  assign answers = cmd_valid && cmd_mode >= 3'd1 && cmd_mode <= 3'd5;
  assign is_wr   = cmd_valid && cmd_mode == 3'd0;
  assign is_rd   = cmd_valid && cmd_mode == 3'd1;
  assign is_add  = cmd_valid && cmd_mode == 3'd5;

  // R9
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !res_valid);

  // R5
  strobe_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    since_rst >= 3'd3 |-> res_valid == $past(answers, 3));

  // R2
  narrow_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 3'd3 && res_valid && !$past(is_add, 3)) |-> !res_data[WIDTH]);

  // R8
  fresh_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 3'd4 && $past(is_wr, 4) && $past(is_rd, 3) &&
     $past(cmd_row, 4) == $past(cmd_row, 3))
    |-> (res_valid && res_data == {1'b0, $past(cmd_wdata, 4)}));
endmodule

bind bitwise_cim_array bitwise_cim_array_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
  .cmd_row(cmd_row), .cmd_wdata(cmd_wdata), .res_valid(res_valid),
  .res_data(res_data)
);

// File: tb/bitwise_cim_array_bench.sv
module bitwise_cim_array_bench;
  localparam int W = 8;
  localparam int N = 8;
  localparam int AW = $clog2(N);
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic [2:0]    cmd_mode = 3'd0;
  logic [AW-1:0] cmd_row = '0;
  logic [W-1:0]  cmd_wdata = '0;
  logic          res_valid;
  logic [W:0]    res_data;

  bitwise_cim_array #(.WIDTH(W), .ROWS(N)) u_bitwise_cim_array (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_row(cmd_row), .cmd_wdata(cmd_wdata), .res_valid(res_valid),
    .res_data(res_data)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] model [N];
  bit           pv [3];
  logic [W:0]   pd [3];
  string        pt [3];

  task automatic check(input bit ok, input string tag, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] pat(input int k, input int r);
    case (k)
      0:       return W'(r * 37 + 19);
      1:       return (r % 2 == 1) ? 8'h01 : 8'hFF;
      2:       return (r % 2 == 1) ? 8'h01 : 8'h0F;
      default: return W'(~(r * 53));
    endcase
  endfunction

  // Called at a falling edge: check the result due now, then drive the next command.
  task automatic step(input bit v, input logic [2:0] md, input int r, input logic [W-1:0] wd, input string tg);
    int p;
    check(res_valid == pv[2], {pt[2], " valid"}, {8'b0, res_valid}, {8'b0, pv[2]});
    if (pv[2]) check(res_data == pd[2], {pt[2], " data"}, res_data, pd[2]);
    pv[2] = pv[1]; pd[2] = pd[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pd[1] = pd[0]; pt[1] = pt[0];
    p = (r == N - 1) ? 0 : r + 1;
    pv[0] = v && md >= 3'd1 && md <= 3'd5;
    pt[0] = tg;
    case (md)
      3'd1: pd[0] = {1'b0, model[r]};
      3'd2: pd[0] = {1'b0, model[r] & model[p]};
      3'd3: pd[0] = {1'b0, model[r] | model[p]};
      3'd4: pd[0] = {1'b0, model[r] ^ model[p]};
      3'd5: pd[0] = {1'b0, model[r]} + {1'b0, model[p]};
      default: pd[0] = '0;
    endcase
    if (v && md == 3'd0) model[r] = wd;
    cmd_valid = v;
    cmd_mode = md;
    cmd_row = AW'(r);
    cmd_wdata = wd;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    for (int i = 0; i < 3; i++) begin pv[i] = 1'b0; pd[i] = '0; pt[i] = "R9"; end
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R9 reset valid", {8'b0, res_valid}, '0);
    check(res_data == '0, "R9 reset data", res_data, '0);
    rst_n = 1'b1;

    for (int r = 0; r < N; r++) step(1, 3'd1, r, '0, "R9");

    for (int k = 0; k < 4; k++) begin
      for (int r = 0; r < N; r++) step(1, 3'd0, r, pat(k, r), "R1");
      for (int r = 0; r < N; r++)
        for (int md = 1; md <= 5; md++) begin
          string tg;
          if (r == N - 1 && md >= 2) tg = "R4";
          else if (md == 1) tg = "R1";
          else if (md <= 4) tg = "R2";
          else if (k == 1 || k == 2) tg = "R10";
          else tg = "R3";
          step(1, 3'(md), r, '0, tg);
        end
    end

    // unused codes, then idle cycles with an otherwise valid code
    step(1, 3'd6, 2, 8'hA5, "R5");
    step(1, 3'd7, 5, 8'h5A, "R5");
    step(0, 3'd1, 3, 8'h00, "R5");
    step(0, 3'd5, 4, 8'h00, "R5");
    for (int r = 0; r < N; r++) step(1, 3'd1, r, '0, "R6");

    // write directly followed by operations on the written row
    step(1, 3'd0, 3, 8'hC3, "R8");
    step(1, 3'd1, 3, '0, "R8");
    step(1, 3'd0, 4, 8'h7E, "R8");
    step(1, 3'd5, 3, '0, "R8");
    step(1, 3'd0, 0, 8'h99, "R8");
    step(1, 3'd4, 7, '0, "R8");

    // mixed back-to-back burst with gaps
    step(1, 3'd5, 1, '0, "R7");
    step(1, 3'd1, 6, '0, "R7");
    step(0, 3'd1, 0, '0, "R7");
    step(1, 3'd3, 2, '0, "R7");
    step(1, 3'd0, 5, 8'h11, "R7");
    step(1, 3'd2, 4, '0, "R7");
    step(1, 3'd5, 7, '0, "R7");

    for (int i = 0; i < 4; i++) step(0, 3'd0, 0, '0, "R5");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule